// File: doc/BRIEF.md
# Counting Semaphore Signal/Wait Unit

This unit carries out the two semaphore primitives, Signal and Wait, on a 32-bit semaphore word that lives in memory. The word counts downward: a value below zero holds available units, one unit per step below zero. A value above zero is not a count. It names a process that system software must deal with, so the unit raises a trap instead of changing the word.

A requester presents an operation code and a word address. The unit reads the word and decides the outcome. It then either writes back the adjusted word or leaves memory alone and raises a trap. The trap carries the vector number for the operation and the semaphore address. From the read request until the write-back is acknowledged, or until the unit decides to trap, the unit drives a bus lock. Other masters must hold off while the lock is high, so the read-modify-write cannot be interleaved with another access. Each operation ends in exactly one of two one-cycle pulses: completion or trap.

A producer/consumer pair sets up its "fill" semaphore at minus the buffer size. The producer's Waits then succeed exactly that many times before a Wait traps.

Top module: `semaphore_unit`

## Requirements
- R1: After reset, reqReady is 1 and memReq, busLock, doneValid and trapValid are all 0.
- R2: Wait (reqOp = 1) on a negative word writes the word plus one back to the same address, then pulses doneValid with no trap.
- R3: Wait on a word of zero or above issues no write, leaves the word unchanged and pulses trapValid with trapVector equal to WAIT_VEC (default 5).
- R4: Signal (reqOp = 0) on a word above zero issues no write, leaves the word unchanged and pulses trapValid with trapVector equal to SIGNAL_VEC (default 4).
- R5: Signal on a word of zero or below writes the word minus one back to the same address, then pulses doneValid with no trap.
- R6: doneValid and trapValid are never high together, and each stays high for exactly one cycle per operation.
- R7: While trapValid is high, trapAddr equals the address of the request that trapped.
- R8: busLock is high in every cycle in which memReq is high, and memAddr holds steady while the lock stays high.
- R9: A request is accepted only while reqReady is 1. A request presented while an operation is in flight has no effect on memory.
- R10: A fill semaphore set to minus N lets exactly N successive Waits complete, and the Wait after them traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation request |
| reqOp | input | 1 | 1 = Wait, 0 = Signal |
| reqAddr | input | ADDR_W | Semaphore word address |
| reqReady | output | 1 | Unit idle, request accepted |
| memReq | output | 1 | Memory access request, held until memAck |
| memWe | output | 1 | 1 = write access, 0 = read access |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Write-back data |
| memRdata | input | DATA_W | Read data, valid with memAck |
| memAck | input | 1 | One-cycle access acknowledge |
| busLock | output | 1 | Exclusive hold on the memory port |
| doneValid | output | 1 | Operation completed without trap |
| trapValid | output | 1 | Operation needs system software |
| trapVector | output | VEC_W | Trap vector number |
| trapAddr | output | ADDR_W | Address of the trapping semaphore |

## Verification
The bench builds the unit with an 8-bit address, a 32-bit word and the default trap vectors 5 and 4. Its memory model acknowledges each access after a two-cycle latency, so a read and a write-back each span several cycles. That latency lets the bench present a competing request mid-transaction and observe lock coverage across a stalled access. The full-width word brings the sign boundary within reach: zero, minus one, positive owner identifiers and a short fill countdown that runs through zero into a trap.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_WRITE,
    ST_RESP
  } semState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeReq;   // capture address and opcode
    logic takeWord;  // capture read data
  } semStrobe_t;

  localparam logic OP_SIGNAL = 1'b0;
  localparam logic OP_WAIT   = 1'b1;

endpackage

// File: rtl/sem_datapath.sv
module sem_datapath
  import sem_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int VEC_W      = 4,
  parameter int WAIT_VEC   = 5,
  parameter int SIGNAL_VEC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  semStrobe_t        strobe,
  input  logic              reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              needTrap,
  output logic [VEC_W-1:0]  trapVector,
  output logic [ADDR_W-1:0] trapAddr
);

  localparam int SIGN_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [ADDR_W-1:0] addrReg;
  logic              opReg;
  logic [DATA_W-1:0] wordReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      opReg   <= OP_SIGNAL;
      wordReg <= '0;
    end else begin
      if (strobe.takeReq) begin
        addrReg <= reqAddr;
        opReg   <= reqOp;
      end
      if (strobe.takeWord) begin
        wordReg <= memRdata;
      end
    end
  end

  logic wordNeg;
  logic wordZero;

  always_comb begin
    wordNeg  = wordReg[SIGN_BIT];
    wordZero = (wordReg == '0);
    if (opReg == OP_WAIT) begin
      needTrap = !wordNeg;              // no unit available
      memWdata = wordReg + ONE;         // take one unit
      trapVector = VEC_W'(WAIT_VEC);
    end else begin
      needTrap = !wordNeg && !wordZero; // owner identifier present
      memWdata = wordReg - ONE;         // release one unit
      trapVector = VEC_W'(SIGNAL_VEC);
    end
  end

  assign memAddr  = addrReg;
  assign trapAddr = addrReg;

endmodule

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memAck,
  input  logic       needTrap,
  output semStrobe_t strobe,
  output logic       reqReady,
  output logic       memReq,
  output logic       memWe,
  output logic       busLock,
  output logic       doneValid,
  output logic       trapValid
);

  semState_e state;
  semState_e stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext       = state;
    strobe.takeReq  = 1'b0;
    strobe.takeWord = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.takeReq = 1'b1;
          stateNext      = ST_READ;
        end
      end
      ST_READ: begin
        if (memAck) begin
          strobe.takeWord = 1'b1;
          stateNext       = ST_EVAL;
        end
      end
      ST_EVAL:  stateNext = needTrap ? ST_RESP : ST_WRITE;
      ST_WRITE: if (memAck) stateNext = ST_RESP;
      ST_RESP:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign reqReady  = (state == ST_IDLE);
  assign memReq    = (state == ST_READ) || (state == ST_WRITE);
  assign memWe     = (state == ST_WRITE);
  assign busLock   = (state == ST_READ) || (state == ST_EVAL) || (state == ST_WRITE);
  assign doneValid = (state == ST_RESP) && !needTrap;
  assign trapValid = (state == ST_RESP) && needTrap;

endmodule

// File: rtl/semaphore_unit.sv
module semaphore_unit
  import sem_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int VEC_W      = 4,
  parameter int WAIT_VEC   = 5,
  parameter int SIGNAL_VEC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic              busLock,
  output logic              doneValid,
  output logic              trapValid,
  output logic [VEC_W-1:0]  trapVector,
  output logic [ADDR_W-1:0] trapAddr
);

  semStrobe_t strobe;
  logic       needTrap;

  sem_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .memAck    (memAck),
    .needTrap  (needTrap),
    .strobe    (strobe),
    .reqReady  (reqReady),
    .memReq    (memReq),
    .memWe     (memWe),
    .busLock   (busLock),
    .doneValid (doneValid),
    .trapValid (trapValid)
  );

  sem_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .VEC_W      (VEC_W),
    .WAIT_VEC   (WAIT_VEC),
    .SIGNAL_VEC (SIGNAL_VEC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqOp      (reqOp),
    .reqAddr    (reqAddr),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .needTrap   (needTrap),
    .trapVector (trapVector),
    .trapAddr   (trapAddr)
  );

endmodule

// File: rtl/semaphore_unit_checker.sv
module semaphore_unit_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busLock,
  input logic              doneValid,
  input logic              trapValid
);

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doneValid && trapValid));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R6
  trap_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> !trapValid);

  // R8
  lock_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busLock);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busLock && $past(busLock)) |-> $stable(memAddr));

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    busLock |-> !reqReady);

  // R2
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && !$past(memReq && memWe)) |-> $past(busLock && !memReq));

endmodule

bind semaphore_unit semaphore_unit_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .busLock   (busLock),
  .doneValid (doneValid),
  .trapValid (trapValid)
);

// File: tb/semaphore_unit_bench.sv
`timescale 1ns/1ps
module semaphore_unit_bench;

  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int VEC_W   = 4;
  localparam int MEM_LAT = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqOp = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqReady;
  logic              memReq;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata;
  logic              memAck;
  logic              busLock;
  logic              doneValid;
  logic              trapValid;
  logic [VEC_W-1:0]  trapVector;
  logic [ADDR_W-1:0] trapAddr;

  always #10 clk = ~clk;

  semaphore_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)) u_semaphore_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqReady(reqReady), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .busLock(busLock),
    .doneValid(doneValid), .trapValid(trapValid), .trapVector(trapVector),
    .trapAddr(trapAddr)
  );

  // memory model with fixed latency
  logic [DATA_W-1:0] mem [16];
  logic              loadEn = 1'b0;
  logic [3:0]        loadAddr = '0;
  logic [DATA_W-1:0] loadData = '0;
  int                latCnt;
  int                writeCount;

  always @(posedge clk) begin
    if (loadEn) mem[loadAddr] <= loadData;
    if (!rstN) begin
      memAck     <= 1'b0;
      memRdata   <= '0;
      latCnt     <= 0;
      writeCount <= 0;
    end else if (memAck) begin
      memAck <= 1'b0;
      latCnt <= 0;
    end else if (memReq) begin
      if (latCnt == MEM_LAT) begin
        memAck <= 1'b1;
        latCnt <= 0;
        if (memWe) begin
          mem[memAddr[3:0]] <= memWdata;
          writeCount <= writeCount + 1;
        end else begin
          memRdata <= mem[memAddr[3:0]];
        end
      end else begin
        latCnt <= latCnt + 1;
      end
    end else begin
      latCnt <= 0;
    end
  end

  int  checks = 0;
  int  errors = 0;
  bit  summaryDone = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic loadWord(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    loadEn = 1'b1; loadAddr = a; loadData = v;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // issue one operation and check its outcome
  task automatic runOp(input logic op, input logic [3:0] a, input logic [31:0] expWord,
                       input bit expTrap, input string req);
    int w0;
    int n;
    bit lockBad;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    w0 = writeCount;
    reqValid = 1'b1; reqOp = op; reqAddr = {4'h0, a};
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    lockBad = 1'b0;
    while (!doneValid && !trapValid && n < 200) begin
      if (memReq && !busLock) lockBad = 1'b1;
      @(negedge clk);
      n++;
    end
    check(n < 200, req, "response seen", n, 0);
    check(!lockBad, "R8", "lock over access", 32'(lockBad), 0);
    check(trapValid == expTrap && doneValid == !expTrap, req, "trap flag",
          32'(trapValid), 32'(expTrap));
    if (expTrap) begin
      check(trapVector == (op ? 4'd5 : 4'd4), req, "vector", 32'(trapVector),
            op ? 32'd5 : 32'd4);
      check(trapAddr == {4'h0, a}, "R7", "trap address", 32'(trapAddr), 32'(a));
    end
    check(writeCount - w0 == (expTrap ? 0 : 1), req, "write count",
          32'(writeCount - w0), expTrap ? 0 : 1);
    check(mem[a] == expWord, req, "memory word", mem[a], expWord);
    @(negedge clk);
    check(!doneValid && !trapValid, "R6", "pulse length",
          32'({doneValid, trapValid}), 0);
  endtask

  task automatic testReset();
    check(reqReady == 1'b1, "R1", "reqReady", 32'(reqReady), 1);
    check(!memReq && !busLock, "R1", "memReq/busLock", 32'({memReq, busLock}), 0);
    check(!doneValid && !trapValid, "R1", "pulses", 32'({doneValid, trapValid}), 0);
  endtask

  task automatic testWait();
    loadWord(4'd1, 32'hFFFF_FFFD);
    runOp(1'b1, 4'd1, 32'hFFFF_FFFE, 1'b0, "R2");
    loadWord(4'd2, 32'hFFFF_FFFF);
    runOp(1'b1, 4'd2, 32'h0000_0000, 1'b0, "R2");
    loadWord(4'd3, 32'h0000_0000);
    runOp(1'b1, 4'd3, 32'h0000_0000, 1'b1, "R3");
    loadWord(4'd4, 32'h0000_1234);
    runOp(1'b1, 4'd4, 32'h0000_1234, 1'b1, "R3");
  endtask

  task automatic testSignal();
    loadWord(4'd5, 32'h0000_0000);
    runOp(1'b0, 4'd5, 32'hFFFF_FFFF, 1'b0, "R5");
    loadWord(4'd6, 32'hFFFF_FFFB);
    runOp(1'b0, 4'd6, 32'hFFFF_FFFA, 1'b0, "R5");
    loadWord(4'd7, 32'h0000_0001);
    runOp(1'b0, 4'd7, 32'h0000_0001, 1'b1, "R4");
    loadWord(4'd8, 32'h7FFF_0040);
    runOp(1'b0, 4'd8, 32'h7FFF_0040, 1'b1, "R4");
  endtask

  task automatic testFill();
    loadWord(4'd9, 32'hFFFF_FFFC);
    for (int i = 0; i < 4; i++) begin
      runOp(1'b1, 4'd9, 32'hFFFF_FFFD + 32'(i), 1'b0, "R10");
    end
    runOp(1'b1, 4'd9, 32'h0000_0000, 1'b1, "R10");
    runOp(1'b0, 4'd9, 32'hFFFF_FFFF, 1'b0, "R10");
  endtask

  task automatic testBusy();
    int w0;
    int n;
    bit readyBad;
    loadWord(4'd10, 32'hFFFF_FFFE);
    loadWord(4'd11, 32'h0000_0000);
    @(negedge clk);
    w0 = writeCount;
    reqValid = 1'b1; reqOp = 1'b1; reqAddr = 8'd10;
    @(negedge clk);
    reqOp = 1'b0; reqAddr = 8'd11;  // competing request held high
    n = 0;
    readyBad = 1'b0;
    while (!doneValid && !trapValid && n < 200) begin
      if (reqReady) readyBad = 1'b1;
      @(negedge clk);
      n++;
    end
    reqValid = 1'b0;
    check(!readyBad, "R9", "reqReady low while busy", 32'(readyBad), 0);
    check(doneValid, "R9", "first op done", 32'(doneValid), 1);
    @(negedge clk);
    @(negedge clk);
    check(mem[11] == 32'h0, "R9", "ignored request word", mem[11], 32'h0);
    check(mem[10] == 32'hFFFF_FFFF, "R9", "first op word", mem[10], 32'hFFFF_FFFF);
    check(writeCount - w0 == 1, "R9", "write count", 32'(writeCount - w0), 1);
    check(reqReady, "R9", "idle again", 32'(reqReady), 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWait();
    testSignal();
    testFill();
    testBusy();
    finishRun();
  end

endmodule